// File: doc/BRIEF.md
# Sequence-Unlocked Block Write Protector

This block sits between the bus front end of a paged EEPROM and its write path. It watches each completed byte-write strobe and recognises two fixed command sequences written to fixed addresses. A three-byte sequence arms protection. A six-byte sequence arms the removal of protection. Each address block has its own protect bit. For every strobe, the block decides in the same cycle whether the byte may reach the array.

Once a sequence completes, a write window opens. Byte loads during the window go through to any address. When the page programming period ends, signalled on `prog_done`, the window closes. At that point the block named by the upper address bits of the sequence's final byte is protected or unprotected. This happens even if no byte was loaded during the window. A protected block therefore accepts data only behind the three-byte prefix. The protect bits survive the logic reset and are cleared only by a dedicated input.

Top module: `blk_wprot`

## Requirements
- R1: After `rst_n` and `prot_clr` are applied together, `prot_state` is all zero and a plain write to any block is permitted.
- R2: Bytes AA, 55, A0 (hex) at low-15-bit addresses 5555, 2AAA, 5555 open a write window. The block selected by bits [16:15] of the third byte's address gets its `prot_state` bit set on the next clock edge that samples `prog_done` high with the window open.
- R3: Bytes AA, 55, 80, AA, 55, 20 at addresses 5555, 2AAA, 5555, 5555, 2AAA, 5555 open a write window. The selected block's bit clears on the `prog_done` edge that closes that window.
- R4: While the window is open, every strobe is permitted regardless of protection. The window closes on the `prog_done` edge.
- R5: A byte that advances or completes a sequence is never permitted.
- R6: Outside a window, a strobe to a protected block is refused, and a strobe to an unprotected block that is not a sequence byte is permitted.
- R7: A byte that breaks a partly matched sequence returns the matcher to idle. That byte is judged as a plain write and does not start a new sequence.
- R8: Protect bits are independent, so any combination of blocks may be protected. At most one bit changes per edge, except when `prot_clr` is applied.
- R9: `rst_n` leaves `prot_state` unchanged. `prot_clr` clears every bit and takes priority over a pending update.
- R10: `prot_state` changes only on a `prog_done` edge with the window open, or on `prot_clr`. `prog_done` outside a window has no effect.
- R11: A window closed by `prog_done` with no byte loaded still applies its set or clear.
- R12: `wr_permit` is combinational with the strobe and is low in any cycle where `wr_stb` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the matcher and window |
| prot_clr | input | 1 | Synchronous clear of all protect bits |
| wr_stb | input | 1 | One-cycle pulse per completed byte write |
| wr_addr | input | ADDR_W | Byte address; top BLK_W bits select the block |
| wr_data | input | 8 | Byte data |
| prog_done | input | 1 | End of the internal programming period |
| wr_permit | output | 1 | High when the strobed byte may be written to the array |
| prot_state | output | 2**BLK_W | Protect bit per block |

## Verification
The bench targets three situations: a sequence broken partway, a window that ends with no bytes loaded, and a `prog_done` pulse that arrives with no window open. If the mismatch byte were swallowed or treated as a new sequence start, a permit would be lost. If an empty window skipped its update, a block would stay writable. If a stray `prog_done` were applied, protection would flip with no command. The bench also checks that sequence bytes aimed at a protected block are never written, that a window's permission covers other blocks, and that the logic reset leaves protection untouched. Any of these errors appears as a wrong `wr_permit` on the strobe cycle or a wrong `prot_state` after the edge.

// File: rtl/bwp_pkg.sv
// Shared constants and types for the block write protector.
// Assumes command addresses are compared on the low CMD_AW bits only.
package bwp_pkg;
    localparam int CMD_AW = 15;
    localparam int DATA_W = 8;

    localparam logic [CMD_AW-1:0] CMD_ADR_HI = 15'h5555;
    localparam logic [CMD_AW-1:0] CMD_ADR_LO = 15'h2AAA;

    localparam logic [DATA_W-1:0] KEY_LEAD   = 8'hAA;
    localparam logic [DATA_W-1:0] KEY_SECOND = 8'h55;
    localparam logic [DATA_W-1:0] KEY_SET    = 8'hA0;
    localparam logic [DATA_W-1:0] KEY_EXT    = 8'h80;
    localparam logic [DATA_W-1:0] KEY_CLEAR  = 8'h20;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_GOT1,
        SQ_GOT2,
        SQ_EXT3,
        SQ_EXT4,
        SQ_EXT5,
        SQ_WIN
    } seq_st_t;
endpackage

// File: rtl/bwp_seq_fsm.sv
// Command sequence matcher.
// Tracks the arm-set prefix and the six-byte arm-clear sequence, and holds
// the write window until the end of the programming period.
// Assumes: stb is a single-cycle pulse per byte; a mismatching byte drops
// the matcher to idle and is not re-examined as a new start.
module bwp_seq_fsm
    import bwp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb,
    input  logic [CMD_AW-1:0] addr_lo,
    input  logic [DATA_W-1:0] data,
    input  logic              prog_done,
    output logic              seq_hit,
    output logic              arm_set,
    output logic              arm_clr,
    output logic              win_open
);
    seq_st_t st_q, st_d;

    logic at_hi, at_lo;
    assign at_hi = (addr_lo == CMD_ADR_HI);
    assign at_lo = (addr_lo == CMD_ADR_LO);

    // Next state and per-byte decode of the command sequences.
    always_comb begin
        st_d    = st_q;
        seq_hit = 1'b0;
        arm_set = 1'b0;
        arm_clr = 1'b0;
        unique case (st_q)
            SQ_IDLE: if (stb && at_hi && data == KEY_LEAD) begin
                st_d = SQ_GOT1; seq_hit = 1'b1;
            end
            SQ_GOT1: if (stb) begin
                if (at_lo && data == KEY_SECOND) begin
                    st_d = SQ_GOT2; seq_hit = 1'b1;
                end else st_d = SQ_IDLE;
            end
            SQ_GOT2: if (stb) begin
                if (at_hi && data == KEY_SET) begin
                    st_d = SQ_WIN; seq_hit = 1'b1; arm_set = 1'b1;
                end else if (at_hi && data == KEY_EXT) begin
                    st_d = SQ_EXT3; seq_hit = 1'b1;
                end else st_d = SQ_IDLE;
            end
            SQ_EXT3: if (stb) begin
                if (at_hi && data == KEY_LEAD) begin
                    st_d = SQ_EXT4; seq_hit = 1'b1;
                end else st_d = SQ_IDLE;
            end
            SQ_EXT4: if (stb) begin
                if (at_lo && data == KEY_SECOND) begin
                    st_d = SQ_EXT5; seq_hit = 1'b1;
                end else st_d = SQ_IDLE;
            end
            SQ_EXT5: if (stb) begin
                if (at_hi && data == KEY_CLEAR) begin
                    st_d = SQ_WIN; seq_hit = 1'b1; arm_clr = 1'b1;
                end else st_d = SQ_IDLE;
            end
            SQ_WIN: if (prog_done) st_d = SQ_IDLE;
            default: st_d = SQ_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= SQ_IDLE;
        else        st_q <= st_d;
    end

    assign win_open = (st_q == SQ_WIN);

    // R4
    window_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_open && !prog_done) |=> win_open);

    // R2
    arm_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_set || arm_clr) |=> win_open);

    // R7
    break_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && !win_open && st_q != SQ_IDLE && !seq_hit) |=> (st_q == SQ_IDLE));
endmodule

// File: rtl/bwp_prot_bank.sv
// Per-block protect bits.
// One bit per block; a bit loads on an apply pulse addressed to it and all
// bits clear on clr. The logic reset does not touch them.
module bwp_prot_bank #(
    parameter int BLK_W = 2,
    localparam int NBLK = 1 << BLK_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             apply,
    input  logic             val,
    input  logic [BLK_W-1:0] sel,
    output logic [NBLK-1:0]  prot
);
    for (genvar g = 0; g < NBLK; g++) begin : g_bit
        // Hold, clear or load this block's protect bit.
        always_ff @(posedge clk) begin
            if (clr)                                 prot[g] <= 1'b0;
            else if (apply && sel == BLK_W'(g))      prot[g] <= val;
        end
    end

    // R10
    prot_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(prot) && !$past(clr)) |-> $past(apply));

    // R8
    one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clr) |-> ($countones(prot ^ $past(prot)) <= 1));

    // R9
    clr_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (prot == '0));
endmodule

// File: rtl/blk_wprot.sv
// Block write protector top.
// Gates byte-write strobes by per-block protection and command sequences.
// Assumes ADDR_W >= CMD_AW + BLK_W and that prog_done marks the end of
// the programming period that follows a byte load.
module blk_wprot
    import bwp_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int BLK_W  = 2,
    localparam int NBLK  = 1 << BLK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prot_clr,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              prog_done,
    output logic              wr_permit,
    output logic [NBLK-1:0]   prot_state
);
    logic             seq_hit, arm_set, arm_clr, win_open;
    logic [BLK_W-1:0] blk_idx;
    logic [BLK_W-1:0] tgt_blk_q;
    logic             tgt_set_q;

    assign blk_idx = wr_addr[ADDR_W-1 -: BLK_W];

    bwp_seq_fsm u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb       (wr_stb),
        .addr_lo   (wr_addr[CMD_AW-1:0]),
        .data      (wr_data),
        .prog_done (prog_done),
        .seq_hit   (seq_hit),
        .arm_set   (arm_set),
        .arm_clr   (arm_clr),
        .win_open  (win_open)
    );

    // Remember which block and which action the completed sequence chose.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_blk_q <= '0;
            tgt_set_q <= 1'b0;
        end else if (arm_set || arm_clr) begin
            tgt_blk_q <= blk_idx;
            tgt_set_q <= arm_set;
        end
    end

    bwp_prot_bank #(.BLK_W(BLK_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (prot_clr),
        .apply (win_open && prog_done),
        .val   (tgt_set_q),
        .sel   (tgt_blk_q),
        .prot  (prot_state)
    );

    // Decide in the strobe cycle whether the byte reaches the array.
    always_comb begin
        wr_permit = wr_stb && rst_n && !seq_hit &&
                    (win_open || !prot_state[blk_idx]);
    end

    // R6
    prot_write_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !win_open && prot_state[blk_idx]) |-> !wr_permit);

    // R5
    seq_byte_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_hit |-> !wr_permit);

    // R12
    idle_no_permit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |-> !wr_permit);

    // R4
    window_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && win_open) |-> wr_permit);
endmodule

// File: tb/blk_wprot_tb_top.sv
module blk_wprot_tb_top;
    localparam int ADDR_W = 17;
    localparam int BLK_W  = 2;
    localparam int NBLK   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0, prot_clr = 1'b1, wr_stb = 1'b0, prog_done = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic wr_permit;
    logic [NBLK-1:0] prot_state;

    always #5 clk = ~clk;

    blk_wprot #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .prot_clr(prot_clr), .wr_stb(wr_stb),
        .wr_addr(wr_addr), .wr_data(wr_data), .prog_done(prog_done),
        .wr_permit(wr_permit), .prot_state(prot_state));

    int checks = 0, fails = 0;

    // Reference model: 0 idle, 1..2 prefix, 3..5 extension, 6 window
    int m_st = 0;
    logic [NBLK-1:0] m_prot = '0;
    int m_tblk = 0;
    bit m_tset = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit is_hi(input logic [ADDR_W-1:0] a);
        return a[14:0] == 15'h5555;
    endfunction
    function automatic bit is_lo(input logic [ADDR_W-1:0] a);
        return a[14:0] == 15'h2AAA;
    endfunction

    // Expected permit for a strobe, then advance the model.
    task automatic model_wr(input logic [ADDR_W-1:0] a, input logic [7:0] d, output bit exp);
        bit hit = 0;
        int blk = int'(a[16:15]);
        int nx = m_st;
        case (m_st)
            0: if (is_hi(a) && d == 8'hAA) begin nx = 1; hit = 1; end
            1: if (is_lo(a) && d == 8'h55) begin nx = 2; hit = 1; end else nx = 0;
            2: if (is_hi(a) && d == 8'hA0) begin nx = 6; hit = 1; m_tblk = blk; m_tset = 1; end
               else if (is_hi(a) && d == 8'h80) begin nx = 3; hit = 1; end else nx = 0;
            3: if (is_hi(a) && d == 8'hAA) begin nx = 4; hit = 1; end else nx = 0;
            4: if (is_lo(a) && d == 8'h55) begin nx = 5; hit = 1; end else nx = 0;
            5: if (is_hi(a) && d == 8'h20) begin nx = 6; hit = 1; m_tblk = blk; m_tset = 0; end
               else nx = 0;
            default: nx = 6;
        endcase
        exp = !hit && (m_st == 6 || !m_prot[blk]);
        m_st = nx;
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d, input string req);
        bit e;
        @(negedge clk);
        wr_stb = 1'b1; wr_addr = a; wr_data = d;
        #1;
        model_wr(a, d, e);
        chk(wr_permit == e, req, int'(wr_permit), int'(e));
        @(posedge clk); #1;
        wr_stb = 1'b0;
    endtask

    task automatic done_pulse();
        @(negedge clk);
        prog_done = 1'b1;
        if (m_st == 6) begin m_prot[m_tblk] = m_tset; m_st = 0; end
        @(posedge clk); #1;
        prog_done = 1'b0;
    endtask

    task automatic chk_prot(input string req);
        @(negedge clk);
        chk(prot_state == m_prot, req, int'(prot_state), int'(m_prot));
    endtask

    function automatic logic [ADDR_W-1:0] cmd_a(input int blk, input bit hi);
        return {2'(blk), hi ? 15'h5555 : 15'h2AAA};
    endfunction

    task automatic seq_set(input int blk, input string req);
        wr(cmd_a(blk,1), 8'hAA, req);
        wr(cmd_a(blk,0), 8'h55, req);
        wr(cmd_a(blk,1), 8'hA0, req);
    endtask

    task automatic seq_clr(input int blk, input string req);
        wr(cmd_a(blk,1), 8'hAA, req);
        wr(cmd_a(blk,0), 8'h55, req);
        wr(cmd_a(blk,1), 8'h80, req);
        wr(cmd_a(blk,1), 8'hAA, req);
        wr(cmd_a(blk,0), 8'h55, req);
        wr(cmd_a(blk,1), 8'h20, req);
    endtask

    bit finished = 0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1; rst_n = 1'b1; prot_clr = 1'b0;
        // R1 reset state
        chk_prot("R1");
        wr({2'd3, 15'h0123}, 8'h11, "R1");
        // R12 no strobe, no permit
        @(negedge clk); #1;
        chk(wr_permit == 1'b0, "R12", int'(wr_permit), 0);

        // R2 arm set on block 2, R5 bytes withheld, R4 window covers other blocks
        seq_set(2, "R5");
        chk_prot("R10");
        wr({2'd0, 15'h0040}, 8'h5A, "R4");
        done_pulse();
        chk_prot("R2");
        chk(prot_state == 4'b0100, "R2", int'(prot_state), 4);
        // R6 plain write to protected and unprotected blocks
        wr({2'd2, 15'h0007}, 8'h01, "R6");
        wr({2'd1, 15'h0007}, 8'h01, "R6");
        // R11 empty window still applies; R8 independent bits
        seq_set(1, "R11");
        done_pulse();
        chk_prot("R11");
        chk(prot_state == 4'b0110, "R8", int'(prot_state), 6);
        // R10 stray prog_done
        done_pulse();
        chk_prot("R10");
        // R7 break mid-sequence, no restart
        wr(cmd_a(0,1), 8'hAA, "R7");
        wr(cmd_a(0,1), 8'hAA, "R7");
        wr(cmd_a(0,0), 8'h55, "R7");
        wr(cmd_a(2,1), 8'hAA, "R7");
        wr(cmd_a(2,0), 8'h33, "R7");
        // R9 logic reset keeps protection
        @(negedge clk); rst_n = 1'b0; m_st = 0;
        @(negedge clk); rst_n = 1'b1;
        chk_prot("R9");
        // R3 clear block 2
        seq_clr(2, "R3");
        wr({2'd2, 15'h0001}, 8'hC3, "R4");
        done_pulse();
        chk_prot("R3");
        chk(prot_state == 4'b0010, "R3", int'(prot_state), 2);
        // R9 explicit clear
        @(negedge clk); prot_clr = 1'b1; m_prot = '0;
        @(negedge clk); prot_clr = 1'b0;
        chk_prot("R9");

        // Random mix
        for (int i = 0; i < 600; i++) begin
            int r = int'($urandom % 10);
            int b = int'($urandom % NBLK);
            if (r < 2) seq_set(b, "R2");
            else if (r == 2) seq_clr(b, "R3");
            else if (r == 3) begin done_pulse(); chk_prot("R10"); end
            else if (r == 4) wr(cmd_a(b, $urandom % 2), 8'($urandom), "R7");
            else if (r == 5) wr(cmd_a(b, 1), 8'hAA, "R5");
            else wr({2'(b), 15'($urandom)}, 8'($urandom), "R6");
        end
        done_pulse();
        chk_prot("R8");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule